// File: doc/BRIEF.md
# Ordering-Table Clear Engine

This block is a write-only DMA channel that lays down an empty, reverse-linked chain of words in memory. Software supplies a start address and a word count, sets the channel enable and pulses the trigger. The engine then writes one word per accepted memory cycle, moving down the address space. Each entry holds the address of the entry just below it, so a reader that starts at the top can follow the chain down to the bottom.

The lowest entry of the chain holds a 24-bit all-ones terminator in place of a pointer. Addresses are word aligned and kept inside the memory span by a size mask, so a chain that runs below address zero continues from the top of memory. When the final word is accepted, the busy flag drops and a one-cycle completion pulse goes to the interrupt logic.

Top module: `ot_clear_dma`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `wr_valid` and `done` are all 0.
- R2: A transfer starts only in a cycle where `chan_en` and `trig` are both 1 while the engine is idle. A trigger without enable, or enable without trigger, issues no write and leaves `busy` at 0.
- R3: The first write address is `start_addr` with bits [1:0] cleared and the bits at and above `MEM_AW` cleared (mask 0x1FFFFC by default). Each write that is not the last has data equal to (address − 4) under that mask, and the next write goes to that value.
- R4: The last write of a chain has data 0x00FFFFFF.
- R5: Decrementing from address 0 wraps to the highest word of memory (0x1FFFFC by default), both in the written pointer and in the next write address.
- R6: A word count of 1 produces exactly one write, which holds the terminator.
- R7: A word count of 0 is treated as 2^CNT_W words (65536 by default).
- R8: `wr_valid` stays 1 from the cycle after the start until the last write is accepted. While `wr_ready` is 0, `wr_addr` and `wr_data` hold. While `wr_ready` is 1, one write is accepted per cycle.
- R9: `done` is 1 for exactly the one cycle after the clock edge that accepts the last write. `busy` is 0 from that cycle on.
- R10: A trigger while `busy` is 1 is ignored. The running chain keeps its addresses and its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 1 | Channel enable |
| trig | input | 1 | Start trigger, acted on only with enable and while idle |
| start_addr | input | ADDR_W (24) | Byte address of the top entry |
| word_count | input | CNT_W (16) | Entries to write; 0 means 2^CNT_W |
| wr_valid | output | 1 | Write request |
| wr_ready | input | 1 | Memory accepts the write this cycle |
| wr_addr | output | ADDR_W (24) | Word-aligned byte address of the write |
| wr_data | output | DATA_W (32) | Link pointer or terminator |
| busy | output | 1 | Chain in progress |
| done | output | 1 | One-cycle completion event |

## Verification
A wrong address register shows up on the very next accepted write: the address no longer equals the pointer written one write earlier. A wrong count shows up at the end of the chain, either as a terminator written too early or too late, or as a `done` pulse that is missing or arrives in the wrong cycle. The wrap case and the count-0 case are the two places where a mask width or counter width error stays hidden until the chain reaches them. The bench therefore runs a chain that crosses address zero and a full-length chain of 2^CNT_W words.

// File: rtl/ot_clear_pkg.sv
// Shared definitions for the ordering-table clear engine.
// Assumes data words are at least 24 bits wide.
package ot_clear_pkg;
    typedef enum logic {
        OT_IDLE = 1'b0,
        OT_RUN  = 1'b1
    } ot_state_e;

    // Chain end marker: 24 low bits set
    localparam logic [23:0] OT_END_MARK = 24'hFF_FFFF;
endpackage

// File: rtl/ot_addr_gen.sv
// Address register of the clear engine. Loads the masked start address and
// steps down one word per accepted write. link_addr is the pointer to the
// word below, wrapped inside the memory span.
// Assumes ADDR_W >= MEM_AW >= 3.
module ot_addr_gen #(
    parameter int ADDR_W = 24,
    parameter int MEM_AW = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] link_addr
);
    localparam logic [ADDR_W:0]   SPAN      = (ADDR_W+1)'(1) << MEM_AW;
    localparam logic [ADDR_W-1:0] WORD_MASK = ADDR_W'(SPAN - 1) & ~ADDR_W'(3);

    logic [ADDR_W-1:0] addr_q;

    // Pointer to the next lower word, wrapped into memory
    always_comb link_addr = (addr_q - ADDR_W'(4)) & WORD_MASK;

    // Load on start, move down one word on each accepted write
    always_ff @(posedge clk) begin
        if (!rst_n)    addr_q <= '0;
        else if (load) addr_q <= start_addr & WORD_MASK;
        else if (step) addr_q <= link_addr;
    end

    assign cur_addr = addr_q;

    // R3: address stays word aligned and inside memory
    p_in_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_q & ~WORD_MASK) == '0);
endmodule

// File: rtl/ot_word_counter.sv
// Remaining-entry counter. A count of zero loads 2^CNT_W. last is set when
// the entry at the current address is the final one.
// Assumes step is never given with nothing left.
module ot_word_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] count_in,
    output logic             last
);
    localparam logic [CNT_W:0] FULL = (CNT_W+1)'(1) << CNT_W;

    logic [CNT_W:0] left_q;

    // Load length (0 means full range), count down per accepted write
    always_ff @(posedge clk) begin
        if (!rst_n)    left_q <= '0;
        else if (load) left_q <= (count_in == '0) ? FULL : {1'b0, count_in};
        else if (step) left_q <= left_q - 1'b1;
    end

    assign last = (left_q == (CNT_W+1)'(1));

    // R7: counter never steps below zero
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> left_q != '0);
endmodule

// File: rtl/ot_ctrl.sv
// Sequencer for the clear engine: waits for enable plus trigger while idle,
// runs until the last write is accepted, then pulses done for one cycle.
// Assumes the memory port holds no state between requests.
module ot_ctrl
    import ot_clear_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chan_en,
    input  logic trig,
    input  logic wr_ready,
    input  logic last,
    output logic load,
    output logic step,
    output logic wr_valid,
    output logic busy,
    output logic done
);
    ot_state_e state_q;
    logic      done_q;

    // Decode start and accept conditions
    always_comb begin
        load     = (state_q == OT_IDLE) && chan_en && trig;
        wr_valid = (state_q == OT_RUN);
        step     = wr_valid && wr_ready;
    end

    // State and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OT_IDLE;
            done_q  <= 1'b0;
        end else begin
            done_q <= step && last;
            if (load)              state_q <= OT_RUN;
            else if (step && last) state_q <= OT_IDLE;
        end
    end

    assign busy = (state_q == OT_RUN);
    assign done = done_q;

    // R9: completion is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: engine is idle when done is raised
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R8: request remains until the final write is taken
    p_keep_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !(wr_ready && last)) |=> wr_valid);
endmodule

// File: rtl/ot_clear_dma.sv
// Ordering-table clear engine top. Writes a downward chain of pointers
// from start_addr, one word per accepted cycle, ending with the terminator.
// Assumes DATA_W >= 24 and ADDR_W <= DATA_W.
module ot_clear_dma
    import ot_clear_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int MEM_AW = 21,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              trig,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  word_count,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              done
);
    localparam logic [DATA_W-1:0] END_WORD = DATA_W'(OT_END_MARK);

    logic              load, step, last;
    logic [ADDR_W-1:0] link_addr;

    ot_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan_en  (chan_en),
        .trig     (trig),
        .wr_ready (wr_ready),
        .last     (last),
        .load     (load),
        .step     (step),
        .wr_valid (wr_valid),
        .busy     (busy),
        .done     (done)
    );

    ot_addr_gen #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .start_addr (start_addr),
        .cur_addr   (wr_addr),
        .link_addr  (link_addr)
    );

    ot_word_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .count_in (word_count),
        .last     (last)
    );

    // Data select: link pointer, or terminator on the final entry
    always_comb wr_data = last ? END_WORD : DATA_W'(link_addr);

    // R8: stalled request holds address and data
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
    // R3: next write lands where the previous pointer pointed
    p_chain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && !last) |=> (wr_valid && wr_addr == $past(wr_data[ADDR_W-1:0])));
    // R1: no request outside a run
    p_valid_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> busy);
endmodule

// File: tb/ot_clear_dma_test.sv
module ot_clear_dma_test;
    localparam logic [23:0] MASK = 24'h1F_FFFC;
    localparam logic [31:0] TERM = 32'h00FF_FFFF;
    localparam int NV = 5;
    localparam logic [23:0] V_ADDR  [NV] = '{24'h000100, 24'h000010, 24'h000008, 24'h3FF102, 24'h000040};
    localparam int          V_COUNT [NV] = '{5, 3, 4, 2, 1};
    localparam bit          V_STALL [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

    logic        clk = 1'b0, rst_n = 1'b0, chan_en = 1'b0, trig = 1'b0, wr_ready = 1'b1;
    logic [23:0] start_addr = '0;
    logic [15:0] word_count = '0;
    logic        wr_valid, busy, done;
    logic [23:0] wr_addr;
    logic [31:0] wr_data;
    int          errors = 0, checks = 0;

    always #2 clk = ~clk;

    ot_clear_dma uut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .trig(trig),
        .start_addr(start_addr), .word_count(word_count),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Pulse the trigger with enable for one cycle; returns at the negedge after
    task automatic kick(input logic [23:0] a, input logic [15:0] n, input logic en);
        start_addr = a; word_count = n; chan_en = en; trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    // Follow a running chain from the current negedge to its done pulse
    task automatic drain(input logic [23:0] a, input int n, input bit stall, input string req);
        logic [23:0] exp_a = a & MASK;
        logic [31:0] exp_d;
        logic [23:0] held_a = '0;
        logic [31:0] held_d = '0;
        bit          held = 1'b0;
        int          idx = 0, cyc = 0;
        while (idx < n) begin
            wr_ready = stall ? ((cyc % 3) != 1) : 1'b1;
            cyc++;
            if (!wr_valid) begin
                check(1'b0, req, "missing write", {31'b0, wr_valid}, 32'h1);
                break;
            end
            if (held)
                check(wr_addr == held_a && wr_data == held_d, "R8", "stall hold",
                      {8'b0, wr_addr}, {8'b0, held_a});
            held = 1'b0;
            if (wr_ready) begin
                exp_d = (idx == n - 1) ? TERM : {8'b0, (exp_a - 24'd4) & MASK};
                check(wr_addr == exp_a, req, "address", {8'b0, wr_addr}, {8'b0, exp_a});
                check(wr_data == exp_d, (idx == n - 1) ? "R4" : req, "data", wr_data, exp_d);
                exp_a = (exp_a - 24'd4) & MASK;
                idx++;
            end else begin
                held = 1'b1; held_a = wr_addr; held_d = wr_data;
            end
            @(negedge clk);
        end
        wr_ready = 1'b1;
        check(done && !busy && !wr_valid, "R9", "done after last",
              {29'b0, done, busy, wr_valid}, 32'h4);
        @(negedge clk);
        check(!done, "R9", "done single cycle", {31'b0, done}, 32'h0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 32'h0, 32'h1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !wr_valid && !done, "R1", "reset state",
              {29'b0, busy, wr_valid, done}, 32'h0);

        // R2: trigger without enable, then enable without trigger
        kick(24'h000100, 16'd4, 1'b0);
        repeat (2) @(negedge clk);
        check(!busy && !wr_valid, "R2", "trigger without enable", {30'b0, busy, wr_valid}, 32'h0);
        chan_en = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && !wr_valid, "R2", "enable without trigger", {30'b0, busy, wr_valid}, 32'h0);

        // Vector table: R3 plain and stalled, R5 wrap, R3 masking, R6 single entry
        for (int i = 0; i < NV; i++) begin
            kick(V_ADDR[i], 16'(V_COUNT[i]), 1'b1);
            drain(V_ADDR[i], V_COUNT[i], V_STALL[i],
                  (i == 2) ? "R5" : (i == 4) ? "R6" : "R3");
            repeat (2) @(negedge clk);
        end

        // R10: trigger during a stalled run is ignored
        wr_ready = 1'b0;
        kick(24'h000200, 16'd3, 1'b1);
        @(negedge clk);
        kick(24'h000800, 16'd1, 1'b1);
        check(busy && wr_addr == 24'h000200, "R10", "retrigger ignored",
              {8'b0, wr_addr}, 32'h200);
        drain(24'h000200, 3, 1'b0, "R10");

        // R7: zero count means full range
        repeat (2) @(negedge clk);
        kick(24'h040000, 16'd0, 1'b1);
        drain(24'h040000, 65536, 1'b0, "R7");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule